// File: doc/BRIEF.md
# Hazard-Aware Thread Selector

This block is the thread-select stage of a single-issue, in-order pipeline that interleaves several hardware threads cycle by cycle. Each cycle it looks at the next instruction of every thread and names the one thread allowed to issue, or reports an empty slot (a bubble). Each thread presents an operation class, a destination register and two source registers, together with a valid flag. Every register identifier is six bits wide: bit 5 picks the file (0 = integer, 1 = floating point) and bits 4:0 give the index.

Two policies are available through `mode`. With `mode` = 0 (rotate), the slot moves one thread forward every cycle. The slot's thread issues only if its operands are ready. Otherwise the slot is a bubble, and the thread tries again on its next turn. With `mode` = 1 (hazard-aware), any valid thread whose operands are ready may issue. A rotating priority that begins just after the last thread to issue decides between them.

Readiness comes from a separate countdown scoreboard for each thread. An issued producer marks its destination busy for a time set by its class. The outputs are registered, so a decision made from the inputs present before clock edge k appears on `sel_valid`/`sel_tid` after edge k. The front end replaces a thread's instruction once it sees that thread reported as issued.

Top module: `hzsel_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `sel_valid` is 0. The first rotate-mode slot after reset belongs to thread 0.
- R2: In rotate mode the slot owner advances by one thread, modulo the thread count, on every cycle, whether or not the slot issues. When two issues follow back to back, the second one's `sel_tid` is the first one's plus one.
- R3: In rotate mode, a slot whose thread is invalid or not ready is a bubble. The held instruction issues on a later turn of that thread once it is ready.
- R4: Class codes are ALU = 0, LOAD = 1, FP = 2. A dependent instruction of the same thread may issue 1 cycle after an ALU producer, 3 cycles after a LOAD and 4 cycles after an FP producer. A dependent that is not ready never issues.
- R5: A store (class 3) that reads an FP result waits the full 4 cycles.
- R6: In hazard-aware mode, threads that are not ready are skipped. Among the eligible threads, the first one at or after (last issued thread + 1) is chosen, wrapping around.
- R7: In hazard-aware mode, when no thread is eligible the slot is a bubble and the priority pointer does not move. All scoreboards keep counting down during bubbles.
- R8: Integer register 0 (identifier 0) is always ready. A write to it never makes it busy.
- R9: Store (3), branch (4) and unused codes (5 to 7) mark no register busy, whatever their destination field holds.
- R10: A pending write in one thread never delays another thread that reads the same register identifier.
- R11: The two register files are separate. A pending write to FP register n never delays a read of integer register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = rotate, 1 = hazard-aware |
| thr_valid | input | NUM_THREADS | Per-thread next-instruction valid |
| thr_cls | input | NUM_THREADS*3 | Per-thread operation class, thread t at bits [3t+2:3t] |
| thr_dst | input | NUM_THREADS*6 | Per-thread destination register identifier |
| thr_src_a | input | NUM_THREADS*6 | Per-thread first source register identifier |
| thr_src_b | input | NUM_THREADS*6 | Per-thread second source register identifier |
| sel_valid | output | 1 | A thread issued in this slot (0 = bubble) |
| sel_tid | output | log2(NUM_THREADS) | Issued thread, zero on a bubble |

## Verification
The assertions take the mode as it was one and two cycles before an output when they check the rotate order. They assume a thread's instruction does not change between being offered and being issued, so that busy marks belong to the instruction actually reported. The bench keeps to these assumptions. It changes a thread's instruction only after that thread is reported as issued or while it is invalid, and it switches policies only between phases of random traffic. Random source and destination registers are drawn from a few low indices in both files, so that dependences and the zero register come up often.

// File: rtl/hzsel_pkg.sv
package hzsel_pkg;

  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_FP     = 3'd2,
    OP_STORE  = 3'd3,
    OP_BRANCH = 3'd4
  } op_class_e;

  localparam logic MODE_ROTATE = 1'b0;
  localparam logic MODE_HAZARD = 1'b1;

  // only producing classes claim a destination
  function automatic logic op_writes(input logic [2:0] c);
    return (c == OP_ALU) || (c == OP_LOAD) || (c == OP_FP);
  endfunction

endpackage

// File: rtl/hzsel_scoreboard.sv
module hzsel_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int CW       = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_REGS):0]   rd_a,
  input  logic [$clog2(NUM_REGS):0]   rd_b,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS):0]   wr_reg,
  input  logic [CW-1:0]               wr_cnt,
  output logic                        rdy_a,
  output logic                        rdy_b
);
  localparam int RW   = $clog2(NUM_REGS) + 1;
  localparam int NENT = 2 * NUM_REGS;

  // cycles left until each register may be read; zero means ready
  logic [CW-1:0] cnt [NENT];

  always_ff @(posedge clk) begin
    for (int e = 0; e < NENT; e++) begin
      if (rst || e == 0)
        cnt[e] <= '0;
      else if (wr_en && wr_reg == RW'(e))
        cnt[e] <= wr_cnt;
      else if (cnt[e] != '0)
        cnt[e] <= cnt[e] - 1'b1;
    end
  end

  assign rdy_a = (cnt[rd_a] == '0);
  assign rdy_b = (cnt[rd_b] == '0);

  // R4
  busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_cnt) != '0 && $past(wr_reg) != '0 &&
     rd_a == $past(wr_reg)) |-> !rdy_a);

  // R8
  zero_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a == '0) |-> rdy_a);

endmodule

// File: rtl/hzsel_arbiter.sv
module hzsel_arbiter #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] req,
  input  logic [TW-1:0] base,
  output logic [NT-1:0] gnt
);
  // first requester at or after base, wrapping
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < NT; i++) begin
      int k;
      k = int'(base) + i;
      if (k >= NT) k = k - NT;
      if (!found && req[k]) begin
        gnt[k] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R6
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);

endmodule

// File: rtl/hzsel_top.sv
module hzsel_top #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_REGS    = 32,
  parameter int LAT_ALU     = 1,
  parameter int LAT_LOAD    = 3,
  parameter int LAT_FP      = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   mode,
  input  logic [NUM_THREADS-1:0]                 thr_valid,
  input  logic [NUM_THREADS*3-1:0]               thr_cls,
  input  logic [NUM_THREADS*($clog2(NUM_REGS)+1)-1:0] thr_dst,
  input  logic [NUM_THREADS*($clog2(NUM_REGS)+1)-1:0] thr_src_a,
  input  logic [NUM_THREADS*($clog2(NUM_REGS)+1)-1:0] thr_src_b,
  output logic                                   sel_valid,
  output logic [(NUM_THREADS>1 ? $clog2(NUM_THREADS) : 1)-1:0] sel_tid
);
  import hzsel_pkg::*;

  localparam int TW      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int RW      = $clog2(NUM_REGS) + 1;
  localparam int LAT_MAX = (LAT_FP > LAT_LOAD) ?
                           ((LAT_FP > LAT_ALU) ? LAT_FP : LAT_ALU) :
                           ((LAT_LOAD > LAT_ALU) ? LAT_LOAD : LAT_ALU);
  localparam int CW      = $clog2(LAT_MAX + 1);

  function automatic logic [TW-1:0] step_tid(input logic [TW-1:0] t);
    if (t == TW'(NUM_THREADS - 1)) return '0;
    else                           return t + 1'b1;
  endfunction

  logic [TW-1:0]          turn_q, pick_tid, next_turn;
  logic                   pick_v;
  logic [NUM_THREADS-1:0] elig, gnt, wr_en_t;

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : g_thr
      op_class_e     cls;
      logic [CW-1:0] cnt_set;
      logic          rdy_a, rdy_b;

      assign cls = op_class_e'(thr_cls[t*3 +: 3]);

      always_comb begin
        case (cls)
          OP_ALU:  cnt_set = CW'(LAT_ALU - 1);
          OP_LOAD: cnt_set = CW'(LAT_LOAD - 1);
          OP_FP:   cnt_set = CW'(LAT_FP - 1);
          default: cnt_set = '0;
        endcase
      end

      assign wr_en_t[t] = pick_v && (pick_tid == TW'(t)) && op_writes(thr_cls[t*3 +: 3]);

      hzsel_scoreboard #(.NUM_REGS(NUM_REGS), .CW(CW)) u_sb (
        .clk    (clk),
        .rst    (rst),
        .rd_a   (thr_src_a[t*RW +: RW]),
        .rd_b   (thr_src_b[t*RW +: RW]),
        .wr_en  (wr_en_t[t]),
        .wr_reg (thr_dst[t*RW +: RW]),
        .wr_cnt (cnt_set),
        .rdy_a  (rdy_a),
        .rdy_b  (rdy_b)
      );

      assign elig[t] = thr_valid[t] && rdy_a && rdy_b;
    end
  endgenerate

  hzsel_arbiter #(.NT(NUM_THREADS), .TW(TW)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (elig),
    .base (turn_q),
    .gnt  (gnt)
  );

  always_comb begin
    if (mode == MODE_HAZARD) begin
      pick_v   = |gnt;
      pick_tid = '0;
      for (int i = 0; i < NUM_THREADS; i++)
        if (gnt[i]) pick_tid = TW'(i);
      next_turn = pick_v ? step_tid(pick_tid) : turn_q;
    end else begin
      pick_tid  = turn_q;
      pick_v    = elig[turn_q];
      next_turn = step_tid(turn_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q    <= '0;
      sel_valid <= 1'b0;
      sel_tid   <= '0;
    end else begin
      turn_q    <= next_turn;
      sel_valid <= pick_v;
      sel_tid   <= pick_v ? pick_tid : '0;
    end
  end

  // R2
  rr_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && $past(sel_valid) && $past(mode) == MODE_ROTATE &&
     $past(mode, 2) == MODE_ROTATE) |-> sel_tid == step_tid($past(sel_tid)));

endmodule

// File: tb/hzsel_top_tb_top.sv
module hzsel_top_tb_top;
  localparam int NT = 4;
  localparam int RW = 6;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst;
  logic mode;
  logic [NT-1:0]    v;
  logic [NT*3-1:0]  cls;
  logic [NT*RW-1:0] dst, sa, sb;
  logic             sv;
  logic [TW-1:0]    st;

  logic       m2;
  logic [1:0] v2;
  logic [5:0] cls2;
  logic [11:0] dst2, sa2, sb2;
  logic       sv2;
  logic [0:0] st2;

  always #2 clk = ~clk;

  hzsel_top dut_i (
    .clk(clk), .rst(rst), .mode(mode), .thr_valid(v), .thr_cls(cls),
    .thr_dst(dst), .thr_src_a(sa), .thr_src_b(sb),
    .sel_valid(sv), .sel_tid(st)
  );

  hzsel_top #(.NUM_THREADS(2)) dut2_i (
    .clk(clk), .rst(rst), .mode(m2), .thr_valid(v2), .thr_cls(cls2),
    .thr_dst(dst2), .thr_src_a(sa2), .thr_src_b(sb2),
    .sel_valid(sv2), .sel_tid(st2)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  int    rdy_at [NT][64];
  int    cyc = 0;
  int    turn_m = 0;
  bit    last_v = 0;
  int    last_t = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat_of(input int c);
    case (c)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic set_thr(input int t, input bit vv, input int c, input int d,
                         input int a, input int b);
    v[t] = vv;
    cls[t*3 +: 3] = 3'(c);
    dst[t*RW +: RW] = 6'(d);
    sa[t*RW +: RW] = 6'(a);
    sb[t*RW +: RW] = 6'(b);
  endtask

  task automatic idle_all();
    for (int t = 0; t < NT; t++) set_thr(t, 0, 3, 0, 0, 0);
  endtask

  // one clock: predict, clock, compare, record
  task automatic step();
    bit el [NT];
    bit ev;
    int et;
    for (int t = 0; t < NT; t++) begin
      int a, b;
      a = int'(sa[t*RW +: RW]);
      b = int'(sb[t*RW +: RW]);
      el[t] = v[t] && (a == 0 || rdy_at[t][a] <= cyc) && (b == 0 || rdy_at[t][b] <= cyc);
    end
    ev = 0; et = 0;
    if (mode == 1'b0) begin
      if (el[turn_m]) begin ev = 1; et = turn_m; end
      turn_m = (turn_m + 1) % NT;
    end else begin
      for (int i = 0; i < NT; i++) begin
        int k;
        k = (turn_m + i) % NT;
        if (!ev && el[k]) begin ev = 1; et = k; end
      end
      if (ev) turn_m = (et + 1) % NT;
    end
    if (ev) begin
      int c, d;
      c = int'(cls[et*3 +: 3]);
      d = int'(dst[et*RW +: RW]);
      if (lat_of(c) > 0 && d != 0) rdy_at[et][d] = cyc + lat_of(c);
    end
    cyc++;
    @(posedge clk);
    @(negedge clk);
    check(sv == ev && (!ev || int'(st) == et), cur_req,
          sv ? int'(st) : -1, ev ? et : -1);
    last_v = ev;
    last_t = et;
  endtask

  // producer on thread 0, then a dependent; returns cycles between issues
  task automatic run_pair(input int pc, input int pd, input int cc, input int cs,
                          input int exp_gap, input string req);
    int gap;
    mode = 1'b1;
    cur_req = req;
    idle_all();
    repeat (5) step();
    set_thr(0, 1, pc, pd, 0, 0);
    step();
    check(last_v && last_t == 0, req, last_v ? last_t : -1, 0);
    set_thr(0, 1, cc, 0, cs, 0);
    gap = 0;
    do begin
      step();
      gap++;
    end while (!last_v && gap < 10);
    check(gap == exp_gap, req, gap, exp_gap);
    idle_all();
  endtask

  initial begin : main
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 64; r++) rdy_at[t][r] = 0;
    void'($urandom(32'd20240613));
    rst = 1'b1; mode = 1'b0;
    v = '0; cls = '0; dst = '0; sa = '0; sb = '0;
    m2 = 1'b0; v2 = '0; cls2 = '0; dst2 = '0; sa2 = '0; sb2 = '0;
    repeat (3) @(negedge clk);
    // R1 outputs idle during reset
    check(sv == 1'b0, "R1", sv, 0);
    check(sv2 == 1'b0, "R1", sv2, 0);
    rst = 1'b0;

    // R1 first rotate slot is thread 0; R3 retry on the two-thread instance
    for (int t = 0; t < NT; t++) set_thr(t, 1, 0, 0, 0, 0);
    v2[0] = 1'b1; cls2[2:0] = 3'd2; dst2[5:0] = 6'h21;
    cur_req = "R1";
    step();
    check(sv && st == 0, "R1", sv ? int'(st) : -1, 0);
    check(sv2 && st2 == 0, "R3", sv2 ? int'(st2) : -1, 0);
    idle_all();
    cls2[2:0] = 3'd0; dst2[5:0] = 6'h00; sa2[5:0] = 6'h21;
    step();
    check(sv2 == 1'b0, "R3", sv2, 0);
    step();
    check(sv2 == 1'b0, "R3", sv2, 0);  // slot of thread 0, operand still busy
    step();
    check(sv2 == 1'b0, "R3", sv2, 0);
    step();
    check(sv2 && st2 == 0, "R3", sv2 ? int'(st2) : -1, 0);
    v2 = '0;

    // R2 rotation with every thread ready
    cur_req = "R2";
    for (int t = 0; t < NT; t++) set_thr(t, 1, 0, 0, 0, 0);
    begin
      int start;
      start = turn_m;
      for (int i = 0; i < 8; i++) begin
        step();
        check(sv && int'(st) == (start + i) % NT, "R2", sv ? int'(st) : -1, (start + i) % NT);
      end
    end
    idle_all();

    run_pair(0, 5, 0, 5, 1, "R4");
    run_pair(1, 6, 0, 6, 3, "R4");
    run_pair(2, 34, 2, 34, 4, "R4");
    run_pair(1, 7, 2, 7, 3, "R7");
    run_pair(2, 35, 3, 35, 4, "R5");
    run_pair(3, 7, 0, 7, 1, "R9");
    run_pair(4, 8, 0, 8, 1, "R9");
    run_pair(1, 0, 0, 0, 1, "R8");
    run_pair(2, 41, 0, 9, 1, "R11");

    // R6 / R7 skip a blocked thread, then bubble, then resume
    cur_req = "R6";
    mode = 1'b1;
    idle_all();
    repeat (5) step();
    set_thr(0, 1, 2, 36, 0, 0);
    step();
    check(last_v && last_t == 0, "R6", last_t, 0);
    set_thr(0, 1, 0, 0, 36, 0);
    set_thr(1, 1, 0, 0, 0, 0);
    set_thr(2, 1, 0, 0, 0, 0);
    step();
    check(sv && st == 1, "R6", sv ? int'(st) : -1, 1);
    set_thr(1, 0, 0, 0, 0, 0);
    step();
    check(sv && st == 2, "R6", sv ? int'(st) : -1, 2);
    set_thr(2, 0, 0, 0, 0, 0);
    step();
    check(sv == 1'b0, "R7", sv, 0);
    step();
    check(sv && st == 0, "R6", sv ? int'(st) : -1, 0);
    idle_all();

    // R10 another thread reads the same register at once
    cur_req = "R10";
    repeat (5) step();
    set_thr(0, 1, 1, 12, 0, 0);
    step();
    set_thr(0, 0, 0, 0, 0, 0);
    set_thr(1, 1, 0, 0, 12, 0);
    step();
    check(sv && st == 1, "R10", sv ? int'(st) : -1, 1);
    idle_all();
    last_v = 0;

    // random traffic in both policies
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) begin
        mode = ~mode;
        cur_req = mode ? "R6" : "R2";
      end
      for (int t = 0; t < NT; t++) begin
        if (!v[t] || (last_v && last_t == t)) begin
          int c, d, a, b;
          c = int'($urandom % 5);
          d = int'(($urandom % 2) * 32 + $urandom % 4);
          a = int'(($urandom % 2) * 32 + $urandom % 4);
          b = int'(($urandom % 2) * 32 + $urandom % 4);
          set_thr(t, ($urandom % 8) != 0, c, d, a, b);
        end
      end
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule